// File: doc/BRIEF.md
# Variable-Length Instruction Length Decoder

This block frames one instruction per cycle out of a window of up to seven instruction bytes that start at the current program counter. The first byte alone decides the instruction length, from one to seven bytes. The second byte only matters for one pair of four-byte encodings. Bytes past the decoded length have no effect on any output.

The block assembles two fields from the framed bytes: a normalized 32-bit opcode word and a 24-bit extension word. The byte order depends on the instruction class. Fixed opcode fields are read most-significant byte first. Embedded immediates are stored least-significant byte first and are swapped into place.

The block also reports the address of the following instruction. All results are registered, so they appear one cycle after the window is offered. A downstream execute stage uses the opcode and extension words without having to know anything about byte order. A fetch stage uses the next-PC value to move the window.

Top module: `insn_len_decoder`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `out_valid` and `out_illegal` are 0.
- R2: Each cycle in which `win_valid` is 1 produces `out_valid` = 1 in the following cycle. A cycle with `win_valid` = 0 produces `out_valid` = 0 and `out_illegal` = 0 in the following cycle.
- R3: The following first bytes (byte 0 = `win_bytes[7:0]`) decode with length 1: 0x00, 0x04, 0x08, 0x0C, 0x10-0x1F, 0x3C-0x3F, 0x40, 0x41, 0x44, 0x45, 0x48, 0x49, 0x4C, 0x4D, 0x50-0x57, 0x60-0x7F, 0xCB, 0xD0-0xDB, 0xE0-0xEF and 0xFF. Any byte in 0x80-0xBF whose bits [3:2] differ from its bits [1:0] also has length 1. For these, the opcode is byte 0 zero-extended and the extension is 0.
- R4: The following first bytes decode with length 2: any byte in 0x80-0xBF with bits [3:2] equal to bits [1:0], and 0x20-0x23, 0x28-0x2B, 0x42, 0x43, 0x46, 0x47, 0x4A, 0x4B, 0x4E, 0x4F, 0x58-0x5F, 0xC0-0xCA, 0xCE, 0xCF and 0xF0-0xF6. The opcode is {byte0, byte1} and the extension is 0.
- R5: First bytes 0x01-0x03, 0x05-0x07, 0x09-0x0B, 0x0D-0x0F, 0x24-0x27, 0x2C-0x3B and 0xCC give length 3. The opcode is {byte0, byte2, byte1} and the extension is 0.
- R6: First bytes 0xDE, 0xDF, 0xF8 and 0xF9 give length 3. The opcode is {byte0, byte1, byte2} and the extension is 0.
- R7: First bytes 0xFA and 0xFB give length 4, with two possible opcode layouts. When byte0 = 0xFA and byte1[7:2] is 0x3C, 0x3D or 0x3E, the opcode is {byte0, byte1, byte2, byte3}. In every other case the opcode is {byte0, byte1, byte3, byte2}. The extension is 0 in both cases.
- R8: First byte 0xCD gives length 5, opcode {byte0, byte2, byte1, byte3} and extension byte4. First byte 0xDC gives length 5, opcode {byte0, byte4, byte3, byte2} and extension byte1.
- R9: First bytes 0xFC and 0xFD give length 6, opcode {byte0, byte1, byte5, byte4} and extension {8'h00, byte3, byte2}.
- R10: First byte 0xDD gives length 7, opcode {byte0, byte4, byte3, byte2} and extension {byte1, byte5, byte6}. First byte 0xFE gives length 7, opcode {byte0, byte1, byte5, byte4} and extension {byte3, byte2, byte6}.
- R11: For a legal instruction, `out_next_pc` equals `win_pc` plus the decoded length, wrapping modulo 2^PC_W.
- R12: First byte 0xF7 is illegal. For one cycle it gives `out_illegal` = 1, length 0, opcode 0, extension 0 and `out_next_pc` equal to `win_pc`. A following legal window clears `out_illegal`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| win_valid | input | 1 | Byte window is valid this cycle |
| win_pc | input | PC_W | Address of byte 0 of the window |
| win_bytes | input | 56 | Seven instruction bytes, byte i at bits [8i+7:8i] |
| out_valid | output | 1 | Registered results are valid |
| out_len | output | 3 | Decoded length in bytes (0 when illegal) |
| out_opcode | output | 32 | Normalized opcode word |
| out_ext | output | 24 | Extension word |
| out_illegal | output | 1 | First byte belongs to no class |
| out_next_pc | output | PC_W | Address of the next instruction |

## Verification
The assertions assume that `win_valid`, `win_pc` and `win_bytes` are settled at every rising clock edge. They also assume that every window carries all seven bytes, even when the instruction is shorter, so that looking back one cycle at the inputs always gives the bytes that were decoded. The stimulus changes inputs only on falling edges and always drives a full seven-byte window. Behind the short opcodes it places distinct filler bytes, so that a wrong byte pick or a wrong swap shows up as a changed value.

// File: rtl/ild_pkg.sv
package ild_pkg;
  localparam int WIN_BYTES = 7;
  localparam int WIN_W     = WIN_BYTES * 8;
  localparam int OPC_W     = 32;
  localparam int EXT_W     = 24;
  localparam int LEN_W     = $clog2(WIN_BYTES + 1);

  // Framing classes: each one fixes the length and the byte layout.
  typedef enum logic [3:0] {
    FMT_ILL,
    FMT_1,
    FMT_2,
    FMT_3LE,
    FMT_3BE,
    FMT_4BE,
    FMT_4MIX,
    FMT_5CD,
    FMT_5DC,
    FMT_6,
    FMT_7DD,
    FMT_7FE
  } ild_fmt_e;

  function automatic logic [LEN_W-1:0] fmt_len(ild_fmt_e f);
    case (f)
      FMT_1:                 return LEN_W'(1);
      FMT_2:                 return LEN_W'(2);
      FMT_3LE, FMT_3BE:      return LEN_W'(3);
      FMT_4BE, FMT_4MIX:     return LEN_W'(4);
      FMT_5CD, FMT_5DC:      return LEN_W'(5);
      FMT_6:                 return LEN_W'(6);
      FMT_7DD, FMT_7FE:      return LEN_W'(7);
      default:               return LEN_W'(0);
    endcase
  endfunction

  function automatic logic [31:0] pc_step(logic [31:0] pc, logic [LEN_W-1:0] len);
    return pc + 32'(len);
  endfunction
endpackage

// File: rtl/ild_classify.sv
module ild_classify
  import ild_pkg::*;
(
  input  logic [7:0] first_byte,
  input  logic [7:0] second_byte,
  output ild_fmt_e   fmt
);
  logic [3:0] hi_nib;
  logic [3:0] lo_nib;
  logic       regs_equal;
  logic       wide_be;

  assign hi_nib     = first_byte[7:4];
  assign lo_nib     = first_byte[3:0];
  assign regs_equal = (first_byte[3:2] == first_byte[1:0]);
  assign wide_be    = (first_byte == 8'hFA) &&
                      ((second_byte[7:2] == 6'h3C) ||
                       (second_byte[7:2] == 6'h3D) ||
                       (second_byte[7:2] == 6'h3E));

  always_comb begin
    fmt = FMT_ILL;
    case (hi_nib)
      4'h0: fmt = (first_byte[1:0] == 2'b00) ? FMT_1 : FMT_3LE;
      4'h1: fmt = FMT_1;
      4'h2: fmt = first_byte[2] ? FMT_3LE : FMT_2;
      4'h3: fmt = (lo_nib >= 4'hC) ? FMT_1 : FMT_3LE;
      4'h4: fmt = first_byte[1] ? FMT_2 : FMT_1;
      4'h5: fmt = first_byte[3] ? FMT_2 : FMT_1;
      4'h6, 4'h7: fmt = FMT_1;
      4'h8, 4'h9, 4'hA, 4'hB: fmt = regs_equal ? FMT_2 : FMT_1;
      4'hC: begin
        case (lo_nib)
          4'hB:    fmt = FMT_1;
          4'hC:    fmt = FMT_3LE;
          4'hD:    fmt = FMT_5CD;
          default: fmt = FMT_2;
        endcase
      end
      4'hD: begin
        case (lo_nib)
          4'hC:       fmt = FMT_5DC;
          4'hD:       fmt = FMT_7DD;
          4'hE, 4'hF: fmt = FMT_3BE;
          default:    fmt = FMT_1;
        endcase
      end
      4'hE: fmt = FMT_1;
      4'hF: begin
        case (lo_nib)
          4'h7:       fmt = FMT_ILL;
          4'h8, 4'h9: fmt = FMT_3BE;
          4'hA:       fmt = wide_be ? FMT_4BE : FMT_4MIX;
          4'hB:       fmt = FMT_4MIX;
          4'hC, 4'hD: fmt = FMT_6;
          4'hE:       fmt = FMT_7FE;
          4'hF:       fmt = FMT_1;
          default:    fmt = FMT_2;
        endcase
      end
      default: fmt = FMT_ILL;
    endcase
  end
endmodule

// File: rtl/ild_pack.sv
module ild_pack
  import ild_pkg::*;
(
  input  ild_fmt_e           fmt,
  input  logic [WIN_W-1:0]   window,
  output logic [OPC_W-1:0]   opcode,
  output logic [EXT_W-1:0]   ext
);
  logic [7:0] bt [WIN_BYTES];

  for (genvar gi = 0; gi < WIN_BYTES; gi++) begin : g_split
    assign bt[gi] = window[8*gi +: 8];
  end

  always_comb begin
    opcode = '0;
    ext    = '0;
    case (fmt)
      FMT_1:    opcode = {24'h0, bt[0]};
      FMT_2:    opcode = {16'h0, bt[0], bt[1]};
      FMT_3LE:  opcode = {8'h0, bt[0], bt[2], bt[1]};
      FMT_3BE:  opcode = {8'h0, bt[0], bt[1], bt[2]};
      FMT_4BE:  opcode = {bt[0], bt[1], bt[2], bt[3]};
      FMT_4MIX: opcode = {bt[0], bt[1], bt[3], bt[2]};
      FMT_5CD: begin
        opcode = {bt[0], bt[2], bt[1], bt[3]};
        ext    = {16'h0, bt[4]};
      end
      FMT_5DC: begin
        opcode = {bt[0], bt[4], bt[3], bt[2]};
        ext    = {16'h0, bt[1]};
      end
      FMT_6: begin
        opcode = {bt[0], bt[1], bt[5], bt[4]};
        ext    = {8'h0, bt[3], bt[2]};
      end
      FMT_7DD: begin
        opcode = {bt[0], bt[4], bt[3], bt[2]};
        ext    = {bt[1], bt[5], bt[6]};
      end
      FMT_7FE: begin
        opcode = {bt[0], bt[1], bt[5], bt[4]};
        ext    = {bt[3], bt[2], bt[6]};
      end
      default: begin
        opcode = '0;
        ext    = '0;
      end
    endcase
  end
endmodule

// File: rtl/insn_len_decoder.sv
module insn_len_decoder
  import ild_pkg::*;
#(
  parameter int PC_W = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 win_valid,
  input  logic [PC_W-1:0]      win_pc,
  input  logic [WIN_W-1:0]     win_bytes,
  output logic                 out_valid,
  output logic [LEN_W-1:0]     out_len,
  output logic [OPC_W-1:0]     out_opcode,
  output logic [EXT_W-1:0]     out_ext,
  output logic                 out_illegal,
  output logic [PC_W-1:0]      out_next_pc
);
  ild_fmt_e            fmt;
  logic [LEN_W-1:0]    dec_len;
  logic [OPC_W-1:0]    dec_opcode;
  logic [EXT_W-1:0]    dec_ext;
  logic [PC_W-1:0]     dec_next_pc;
  logic                dec_fire;
  logic                dec_illegal;

  ild_classify u_classify (
    .first_byte  (win_bytes[7:0]),
    .second_byte (win_bytes[15:8]),
    .fmt         (fmt)
  );

  ild_pack u_pack (
    .fmt    (fmt),
    .window (win_bytes),
    .opcode (dec_opcode),
    .ext    (dec_ext)
  );

  assign dec_len     = fmt_len(fmt);
  assign dec_fire    = win_valid;
  assign dec_illegal = win_valid && (fmt == FMT_ILL);
  assign dec_next_pc = PC_W'(pc_step(32'(win_pc), dec_len));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_illegal <= 1'b0;
      out_len     <= '0;
      out_opcode  <= '0;
      out_ext     <= '0;
      out_next_pc <= '0;
    end else if (dec_fire) begin
      out_valid   <= 1'b1;
      out_illegal <= dec_illegal;
      out_len     <= dec_len;
      out_opcode  <= dec_opcode;
      out_ext     <= dec_ext;
      out_next_pc <= dec_next_pc;
    end else begin
      out_valid   <= 1'b0;
      out_illegal <= 1'b0;
    end
  end
endmodule

// File: rtl/ild_checker.sv
module ild_checker
  import ild_pkg::*;
#(
  parameter int PC_W = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic               win_valid,
  input logic [PC_W-1:0]    win_pc,
  input logic [WIN_W-1:0]   win_bytes,
  input logic               out_valid,
  input logic [LEN_W-1:0]   out_len,
  input logic [OPC_W-1:0]   out_opcode,
  input logic [EXT_W-1:0]   out_ext,
  input logic               out_illegal,
  input logic [PC_W-1:0]    out_next_pc,
  input logic               dec_illegal
);
  assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    win_valid |=> out_valid);

  assert_idle_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !win_valid |=> (!out_valid && !out_illegal));

  assert_single_byte_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_len == LEN_W'(1)) |-> (out_ext == '0 && out_opcode[31:8] == 24'h0));

  assert_two_byte_head_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_len == LEN_W'(2)) |->
      (out_opcode[31:16] == 16'h0 && out_ext == '0 && out_opcode[15:8] == $past(win_bytes[7:0])));

  assert_three_byte_head_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_len == LEN_W'(3)) |->
      (out_opcode[31:24] == 8'h0 && out_opcode[23:16] == $past(win_bytes[7:0])));

  assert_pc_advance_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_illegal) |->
      (out_next_pc == $past(win_pc) + PC_W'(out_len) && out_len != '0));

  assert_illegal_holds_pc_R12: assert property (@(posedge clk) disable iff (!rst_n)
    out_illegal |-> (out_valid && out_len == '0 && out_next_pc == $past(win_pc)));

  assert_illegal_flag_R12: assert property (@(posedge clk) disable iff (!rst_n)
    dec_illegal |=> out_illegal);
endmodule

bind insn_len_decoder ild_checker #(.PC_W(PC_W)) u_ild_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .win_valid   (win_valid),
  .win_pc      (win_pc),
  .win_bytes   (win_bytes),
  .out_valid   (out_valid),
  .out_len     (out_len),
  .out_opcode  (out_opcode),
  .out_ext     (out_ext),
  .out_illegal (out_illegal),
  .out_next_pc (out_next_pc),
  .dec_illegal (dec_illegal)
);

// File: tb/test_insn_len_decoder.sv
`timescale 1ns/1ps
module test_insn_len_decoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        win_valid = 1'b0;
  logic [31:0] win_pc = '0;
  logic [55:0] win_bytes = '0;
  logic        out_valid;
  logic [2:0]  out_len;
  logic [31:0] out_opcode;
  logic [23:0] out_ext;
  logic        out_illegal;
  logic [31:0] out_next_pc;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  insn_len_decoder #(.PC_W(32)) i_insn_len_decoder (
    .clk(clk), .rst_n(rst_n), .win_valid(win_valid), .win_pc(win_pc),
    .win_bytes(win_bytes), .out_valid(out_valid), .out_len(out_len),
    .out_opcode(out_opcode), .out_ext(out_ext), .out_illegal(out_illegal),
    .out_next_pc(out_next_pc)
  );

  function automatic logic [55:0] mkwin(logic [7:0] b0, logic [7:0] b1);
    return {8'h66, 8'h55, 8'h44, 8'h33, 8'h22, b1, b0};
  endfunction

  task automatic cmp(string req, string what, logic [63:0] act, logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic run(string req, logic [31:0] pc, logic [55:0] w, int exp_len,
                     logic [31:0] exp_op, logic [23:0] exp_ext, bit exp_ill);
    logic [31:0] exp_pc;
    exp_pc = exp_ill ? pc : pc + 32'(exp_len);
    @(negedge clk);
    win_valid = 1'b1; win_pc = pc; win_bytes = w;
    @(posedge clk); #1;
    cmp(req, "valid", 64'(out_valid), 64'd1);
    cmp(req, "len", 64'(out_len), 64'(exp_len));
    cmp(req, "opcode", 64'(out_opcode), 64'(exp_op));
    cmp(req, "ext", 64'(out_ext), 64'(exp_ext));
    cmp(req, "illegal", 64'(out_illegal), 64'(exp_ill));
    cmp(req, "next_pc", 64'(out_next_pc), 64'(exp_pc));
    @(negedge clk);
    win_valid = 1'b0;
  endtask

  task automatic test_reset();
    #1;
    cmp("R1", "valid in reset", 64'(out_valid), 64'd0);
    cmp("R1", "illegal in reset", 64'(out_illegal), 64'd0);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    cmp("R1", "valid after reset", 64'(out_valid), 64'd0);
    cmp("R1", "illegal after reset", 64'(out_illegal), 64'd0);
  endtask

  task automatic test_one_byte();
    run("R3", 32'h100, mkwin(8'h3C, 8'h11), 1, 32'h3C, 24'h0, 0);
    run("R3", 32'h200, mkwin(8'h81, 8'h11), 1, 32'h81, 24'h0, 0);
    run("R3", 32'h300, mkwin(8'hFF, 8'h11), 1, 32'hFF, 24'h0, 0);
    run("R3", 32'h304, mkwin(8'h4D, 8'h11), 1, 32'h4D, 24'h0, 0);
  endtask

  task automatic test_two_byte();
    run("R4", 32'h400, mkwin(8'h85, 8'h11), 2, 32'h8511, 24'h0, 0);
    run("R4", 32'h410, mkwin(8'hC5, 8'h11), 2, 32'hC511, 24'h0, 0);
    run("R4", 32'h420, mkwin(8'hF6, 8'h11), 2, 32'hF611, 24'h0, 0);
    run("R4", 32'h430, mkwin(8'h4A, 8'h11), 2, 32'h4A11, 24'h0, 0);
  endtask

  task automatic test_three_byte();
    run("R5", 32'h500, mkwin(8'h2C, 8'h11), 3, 32'h2C2211, 24'h0, 0);
    run("R5", 32'h510, mkwin(8'hCC, 8'h11), 3, 32'hCC2211, 24'h0, 0);
    run("R6", 32'h520, mkwin(8'hF9, 8'h11), 3, 32'hF91122, 24'h0, 0);
    run("R6", 32'h530, mkwin(8'hDE, 8'h11), 3, 32'hDE1122, 24'h0, 0);
  endtask

  task automatic test_four_byte();
    run("R7", 32'h600, mkwin(8'hFB, 8'h11), 4, 32'hFB113322, 24'h0, 0);
    run("R7", 32'h610, mkwin(8'hFA, 8'hF5), 4, 32'hFAF52233, 24'h0, 0);
    run("R7", 32'h620, mkwin(8'hFA, 8'hFC), 4, 32'hFAFC3322, 24'h0, 0);
    run("R7", 32'h630, mkwin(8'hFB, 8'hF0), 4, 32'hFBF03322, 24'h0, 0);
  endtask

  task automatic test_five_byte();
    run("R8", 32'h700, mkwin(8'hCD, 8'h11), 5, 32'hCD221133, 24'h44, 0);
    run("R8", 32'h710, mkwin(8'hDC, 8'h11), 5, 32'hDC443322, 24'h11, 0);
  endtask

  task automatic test_six_byte();
    run("R9", 32'h800, mkwin(8'hFC, 8'h11), 6, 32'hFC115544, 24'h003322, 0);
    run("R9", 32'h810, mkwin(8'hFD, 8'h11), 6, 32'hFD115544, 24'h003322, 0);
  endtask

  task automatic test_seven_byte();
    run("R10", 32'h900, mkwin(8'hDD, 8'h11), 7, 32'hDD443322, 24'h115566, 0);
    run("R10", 32'h910, mkwin(8'hFE, 8'h11), 7, 32'hFE115544, 24'h332266, 0);
  endtask

  task automatic test_pc_wrap();
    run("R11", 32'hFFFF_FFFE, mkwin(8'hFE, 8'h11), 7, 32'hFE115544, 24'h332266, 0);
    cmp("R11", "wrapped pc", 64'(out_next_pc), 64'h5);
  endtask

  task automatic test_illegal();
    run("R12", 32'hA00, mkwin(8'hF7, 8'h11), 0, 32'h0, 24'h0, 1);
    @(negedge clk);
    win_valid = 1'b1; win_pc = 32'hB00; win_bytes = mkwin(8'hF7, 8'h11);
    @(negedge clk);
    win_pc = 32'hB00; win_bytes = mkwin(8'h10, 8'h11);
    @(posedge clk); #1;
    cmp("R12", "illegal cleared by legal window", 64'(out_illegal), 64'd0);
    cmp("R12", "pc after legal", 64'(out_next_pc), 64'hB01);
    @(negedge clk); win_valid = 1'b0;
  endtask

  task automatic test_idle_gap();
    run("R2", 32'hC00, mkwin(8'h20, 8'h11), 2, 32'h2011, 24'h0, 0);
    @(posedge clk); #1;
    cmp("R2", "valid low after idle", 64'(out_valid), 64'd0);
    cmp("R2", "illegal low after idle", 64'(out_illegal), 64'd0);
  endtask

  initial begin
    test_reset();
    test_one_byte();
    test_two_byte();
    test_three_byte();
    test_four_byte();
    test_five_byte();
    test_six_byte();
    test_seven_byte();
    test_pc_wrap();
    test_illegal();
    test_idle_gap();
    if (!finished) begin
      finished = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    #(5.0 * 100000);
    if (!finished) begin
      finished = 1;
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  end
endmodule